// File: doc/BRIEF.md
# Multi-Channel Decode Job Scheduler

This block shares a single frame decoder among up to four decode channels. A host opens a channel with a create request. The scheduler gives the new channel the lowest free slot index, so channels opened one after another on an empty table get 0, 1, 2 and 3. The host closes a channel with a destroy request, and that frees its slot for reuse. Each channel may carry a different stream format. The scheduler does not look at format at all; it only deals with slots.

Nothing is dispatched until the host gives a start command. After that, whenever the decoder is idle, the scheduler picks one channel that is allocated and whose stream-ready input is high. Selection is a rotating round robin with no priority. The scheduler pulses a start strobe together with the channel index and raises a busy flag. The busy flag stays high until the decoder reports that the frame is done. One frame decode forms one time slice.

Top module: `decode_sched`

## Requirements
- R1: After a synchronous reset, no channel is allocated, busy and the dispatch strobe are low, and the create acknowledge and create error are low.
- R2: A create request with a free slot allocates the lowest-numbered free slot. It gives a one-cycle acknowledge in the next cycle, with that slot number on the create index output. Four creates into an empty table return 0, 1, 2, 3 in that order.
- R3: A create request when all four slots are live gives a one-cycle error pulse and no acknowledge, and the live mask does not change.
- R4: A destroy request for a live slot clears that slot's bit in the live mask in the next cycle. A destroy for a slot that is not live leaves the mask unchanged. A freed slot is the one handed out by the next create.
- R5: No dispatch happens before the host has issued the start command, even if live channels are ready.
- R6: A dispatch only ever selects a channel that was both live and stream-ready in the cycle it was chosen. With no such channel, no dispatch occurs.
- R7: A dispatch is a one-cycle strobe carrying the chosen index on the decoder index output. Busy rises in the same cycle. No further strobe occurs while busy is high.
- R8: When the decoder's done input is sampled high while busy, busy is low in the next cycle. If a channel is eligible, the next strobe appears exactly one cycle after that.
- R9: After serving channel i, the search for the next channel starts at i+1, wraps from 3 to 0, and skips slots that are not live or not ready.
- R10: A done input while the scheduler is idle has no effect: busy stays low and no strobe results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| create_req | input | 1 | Request to open a new channel |
| create_ack | output | 1 | One-cycle pulse: channel opened |
| create_err | output | 1 | One-cycle pulse: table full, request refused |
| create_idx | output | 2 | Slot number given by the last acknowledged create |
| destroy_req | input | 1 | Request to close the channel in destroy_idx |
| destroy_idx | input | 2 | Slot to close |
| start_req | input | 1 | Enables scheduling (sticky until reset) |
| stream_rdy | input | 4 | Per-slot flag: stream data is present |
| chan_live | output | 4 | Mask of allocated slots |
| dec_start | output | 1 | One-cycle strobe: decoder begins a frame |
| dec_idx | output | 2 | Channel being decoded |
| dec_done | input | 1 | Decoder finished the current frame |
| busy | output | 1 | Frame decode in progress |

## Verification
A corrupted rotation pointer appears at the very next dispatch as an index out of turn. That is why the bench walks complete rotations, then sparse ready patterns and an absent slot, and checks each strobe's index. A busy/idle state that is out of step shows up within one cycle as a missing strobe or an extra strobe around the done handshake, so the cycle right after done is checked exactly. Slot bookkeeping errors show up at once on the live mask and on the index that the following create returns.

// File: rtl/dsch_pkg.sv
package dsch_pkg;

    localparam int NCH = 4;
    localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef logic [IDW-1:0] chan_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_BUSY = 1'b1
    } eng_e;

    typedef struct packed {
        logic  found;
        chan_t idx;
    } pick_t;

    function automatic chan_t next_slot(input chan_t cur);
        if (int'(cur) == NCH - 1)
            return '0;
        return chan_t'(int'(cur) + 1);
    endfunction

endpackage

// File: rtl/dsch_slots.sv
module dsch_slots
    import dsch_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         create_req,
    input  logic         destroy_req,
    input  chan_t        destroy_idx,
    output logic [N-1:0] live,
    output logic         create_ack,
    output logic         create_err,
    output chan_t        create_idx
);

    pick_t free_pick;

    always_comb begin
        free_pick = '0;
        for (int s = N - 1; s >= 0; s--) begin
            if (!live[s]) begin
                free_pick.found = 1'b1;
                free_pick.idx   = chan_t'(s);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live       <= '0;
            create_ack <= 1'b0;
            create_err <= 1'b0;
            create_idx <= '0;
        end else begin
            create_ack <= 1'b0;
            create_err <= 1'b0;
            if (destroy_req && live[destroy_idx])
                live[destroy_idx] <= 1'b0;
            if (create_req) begin
                if (free_pick.found) begin
                    live[free_pick.idx] <= 1'b1;
                    create_ack          <= 1'b1;
                    create_idx          <= free_pick.idx;
                end else begin
                    create_err <= 1'b1;
                end
            end
        end
    end

    // R2
    ack_fresh_chk: assert property (@(posedge clk) disable iff (rst)
        create_ack |-> (($past(live) & (N'(1) << create_idx)) == '0));

    // R3
    err_full_chk: assert property (@(posedge clk) disable iff (rst)
        create_err |-> (&$past(live)) && !create_ack);

    // R4
    stray_destroy_chk: assert property (@(posedge clk) disable iff (rst)
        (destroy_req && !live[destroy_idx] && !create_req) |=> live == $past(live));

endmodule

// File: rtl/dsch_rr.sv
module dsch_rr
    import dsch_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic [N-1:0] req,
    input  chan_t        ptr,
    output pick_t        pick
);

    always_comb begin
        pick = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int c;
            c = (int'(ptr) + k) % N;
            if (req[c]) begin
                pick.found = 1'b1;
                pick.idx   = chan_t'(c);
            end
        end
    end

endmodule

// File: rtl/decode_sched.sv
module decode_sched
    import dsch_pkg::*;
#(
    parameter int NUM_CH = NCH,
    localparam int IW = IDW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              create_req,
    output logic              create_ack,
    output logic              create_err,
    output logic [IW-1:0]     create_idx,
    input  logic              destroy_req,
    input  logic [IW-1:0]     destroy_idx,
    input  logic              start_req,
    input  logic [NUM_CH-1:0] stream_rdy,
    output logic [NUM_CH-1:0] chan_live,
    output logic              dec_start,
    output logic [IW-1:0]     dec_idx,
    input  logic              dec_done,
    output logic              busy
);

    eng_e              state;
    logic              running;
    chan_t             rr_ptr;
    logic [NUM_CH-1:0] eligible;
    pick_t             pick;

    dsch_slots #(.N(NUM_CH)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .create_req (create_req),
        .destroy_req(destroy_req),
        .destroy_idx(destroy_idx),
        .live       (chan_live),
        .create_ack (create_ack),
        .create_err (create_err),
        .create_idx (create_idx)
    );

    assign eligible = chan_live & stream_rdy;

    dsch_rr #(.N(NUM_CH)) u_rr (
        .req (eligible),
        .ptr (rr_ptr),
        .pick(pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ENG_IDLE;
            running   <= 1'b0;
            rr_ptr    <= '0;
            dec_start <= 1'b0;
            dec_idx   <= '0;
        end else begin
            dec_start <= 1'b0;
            if (start_req)
                running <= 1'b1;
            case (state)
                ENG_IDLE: begin
                    if (running && pick.found) begin
                        state     <= ENG_BUSY;
                        dec_start <= 1'b1;
                        dec_idx   <= pick.idx;
                        rr_ptr    <= next_slot(pick.idx);
                    end
                end
                ENG_BUSY: begin
                    if (dec_done)
                        state <= ENG_IDLE;
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    assign busy = (state == ENG_BUSY);

    // R5
    start_after_go_chk: assert property (@(posedge clk) disable iff (rst)
        dec_start |-> $past(running));

    // R6
    start_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        dec_start |-> (($past(eligible) & (NUM_CH'(1) << dec_idx)) != '0));

    // R7
    start_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        dec_start |-> !$past(busy) && busy);

    // R8
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && dec_done) |=> !busy && !dec_start);

endmodule

// File: tb/decode_sched_test.sv
module decode_sched_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       create_req, destroy_req, start_req, dec_done;
    logic [1:0] destroy_idx;
    logic [3:0] stream_rdy;
    logic       create_ack, create_err, dec_start, busy;
    logic [1:0] create_idx, dec_idx;
    logic [3:0] chan_live;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    decode_sched uut (
        .clk(clk), .rst(rst),
        .create_req(create_req), .create_ack(create_ack),
        .create_err(create_err), .create_idx(create_idx),
        .destroy_req(destroy_req), .destroy_idx(destroy_idx),
        .start_req(start_req), .stream_rdy(stream_rdy),
        .chan_live(chan_live), .dec_start(dec_start),
        .dec_idx(dec_idx), .dec_done(dec_done), .busy(busy)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; create_req = 0; destroy_req = 0; destroy_idx = 0;
        start_req = 0; dec_done = 0; stream_rdy = 4'b0000;
        tick(); tick();
        rst = 1'b0;
        tick();
        check("R1 live", chan_live, 0);
        check("R1 busy", busy, 0);
        check("R1 start", dec_start, 0);
        check("R1 ack/err", {create_ack, create_err}, 0);
    endtask

    task automatic do_create(input string req, input int exp_ack, input int exp_idx);
        create_req = 1'b1;
        tick();
        create_req = 1'b0;
        check({req, " ack"}, create_ack, exp_ack);
        check({req, " err"}, create_err, !exp_ack);
        if (exp_ack) check({req, " idx"}, create_idx, exp_idx);
        tick();
        check({req, " pulse"}, {create_ack, create_err}, 0);
    endtask

    task automatic do_destroy(input int idx);
        destroy_req = 1'b1; destroy_idx = 2'(idx);
        tick();
        destroy_req = 1'b0;
    endtask

    task automatic t_fill();
        for (int i = 0; i < 4; i++) do_create("R2", 1, i);
        check("R2 live", chan_live, 4'b1111);
    endtask

    task automatic t_full();
        do_create("R3", 0, 0);
        check("R3 live", chan_live, 4'b1111);
    endtask

    task automatic t_destroy();
        do_destroy(1);
        check("R4 destroy", chan_live, 4'b1101);
        do_destroy(1);
        check("R4 stray destroy", chan_live, 4'b1101);
        do_create("R4 reuse", 1, 1);
        check("R4 live", chan_live, 4'b1111);
    endtask

    task automatic t_no_start();
        int seen = 0;
        stream_rdy = 4'b1111;
        for (int i = 0; i < 6; i++) begin
            tick();
            if (dec_start || busy) seen++;
        end
        check("R5 no dispatch before start", seen, 0);
    endtask

    task automatic t_done_idle();
        dec_done = 1'b1;
        tick();
        dec_done = 1'b0;
        check("R10 busy", busy, 0);
        tick();
        check("R10 start", dec_start, 0);
    endtask

    // Dispatch is expected exactly in the next cycle.
    task automatic serve(input int exp);
        tick();
        check("R7/R8 strobe", dec_start, 1);
        check("R9 index", dec_idx, exp);
        check("R7 busy", busy, 1);
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R7 no strobe while busy", {dec_start, busy}, 1);
        end
        dec_done = 1'b1;
        tick();
        dec_done = 1'b0;
        check("R8 busy cleared", {busy, dec_start}, 0);
    endtask

    task automatic t_rotate();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        serve(0); serve(1); serve(2); serve(3); serve(0);
    endtask

    task automatic t_skip();
        stream_rdy = 4'b1010;
        serve(1); serve(3); serve(1);
        stream_rdy = 4'b0000;
        tick();
        check("R6 none ready", {dec_start, busy}, 0);
        do_destroy(3);
        check("R4 destroy 3", chan_live, 4'b0111);
        stream_rdy = 4'b1111;
        serve(2); serve(0); serve(1);
        stream_rdy = 4'b0000;
        tick();
        check("R6 idle", dec_start, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_fill();
                t_full();
                t_destroy();
                t_no_start();
                t_done_idle();
                t_rotate();
                t_skip();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule